// File: doc/BRIEF.md
# Serial Register Access Port with Runtime Wiring and Bit-Order Control

This block is a serial slave that lets an external controller read and write a byte-wide register space inside the chip. Every transaction is framed by an active-low select. It carries a 16-bit instruction, made of one direction bit and a 15-bit address, followed by one data byte. Writes to any address other than zero go out on a one-cycle register write strobe. Reads to those addresses take their data from a register read input and shift it back to the controller.

Address zero holds the port's own configuration register. That register chooses the wiring: either a separate output pin (4-wire) or one shared bidirectional data pin (3-wire). It also chooses the bit order (most or least significant bit first) and holds a self-clearing soft reset. The register only accepts a value whose low nibble is the high nibble in reversed bit order and whose long-instruction bit is 1. New wiring and bit-order settings take effect once the select of the writing transaction is released.

The serial clock and select are oversampled by the system clock. The serial clock half period must last at least three system clocks. The data pad is split into an input, an output and an output enable.

Top module: `spi_reg_port`

## Requirements
- R1: After reset the configuration register reads 0x18, so the port is in 4-wire mode with MSB-first order. In that state reg_we_o, soft_rst_o, sdo_o and sdio_oe_o are all 0.
- R2: The port captures a data bit on each rising serial clock edge while select is low, 24 bits per frame. In MSB-first order the frame is sent as: the direction bit (1 = read, 0 = write), then address bits 14 down to 0, then data bits 7 down to 0.
- R3: In LSB-first order (configuration bit 6 = 1) the 16-bit instruction {direction, address} is sent bit 0 first, so address bit 0 comes first and the direction bit comes last. Written data and read data are both sent bit 0 first.
- R4: A complete write frame to a nonzero address produces a reg_we_o pulse exactly one clock wide, with that address on reg_addr_o and that byte on reg_wdata_o. The pulse appears on the clock after the one that samples the 24th rising serial clock edge.
- R5: For a read, reg_addr_o holds the address once the 16th bit has been taken. The first data bit is valid before the 17th rising edge, and each later bit is valid after the preceding falling edge.
- R6: In 4-wire mode (configuration bit 7 = 0) read data appears on sdo_o and sdio_oe_o stays 0.
- R7: In 3-wire mode (configuration bit 7 = 1) read data appears on sdio_o. sdio_oe_o is 1 only during the data phase of a read while select is low, and sdo_o stays 0.
- R8: A write to address 0 is accepted only when bits [3:0] equal bits [4], [5], [6], [7] in that order and bit 4 is 1. Any other value leaves the register unchanged.
- R9: A change of wiring or bit order becomes active when select is released after the writing frame. The next frame uses the new setting.
- R10: Accepting a value with bit 5 set raises soft_rst_o for one clock. After that clock the configuration register is back to 0x18 and the port is back in 4-wire, MSB-first operation.
- R11: A frame cut short by select rising before 24 bits writes nothing. Serial clock edges after the 24th bit of a frame are ignored.
- R12: A read of address 0 returns the configuration register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Serial data in (data pin input side) |
| sdio_o | output | 1 | Data pin output value in 3-wire mode |
| sdio_oe_o | output | 1 | Data pin output enable in 3-wire mode |
| sdo_o | output | 1 | Dedicated serial output in 4-wire mode |
| reg_addr_o | output | 15 | Register address of the current frame |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-clock register write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |
| soft_rst_o | output | 1 | One-clock soft reset pulse |

## Verification
The write strobe and the soft reset pulse are both due on the clock after the one that samples the 24th rising serial clock edge. The read-side output enable is due two clocks after the 16th rising edge: one clock to detect the edge and one to load the shift register. The bench turns each of these timings into an expected clock index the moment it drives the edge. A per-clock model then compares reg_we_o, soft_rst_o, sdio_oe_o and sdo_o against those indices on every cycle, half a clock away from the active edge. Read bits are sampled just before each data-phase rising edge. Effects that only appear at select release, such as accepted configuration, a new bit order or wiring, are checked through the following frame.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W  = 15;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = ADDR_W + 1;
  localparam int FRAME_W = INSTR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam int B_BIDIR = 7;
  localparam int B_LSB   = 6;
  localparam int B_SOFT  = 5;
  localparam int B_LONG  = 4;
  localparam logic [DATA_W-1:0] CTRL_DEF = 8'h18;

  function automatic logic [INSTR_W-1:0] rev_instr(input logic [INSTR_W-1:0] v);
    for (int i = 0; i < INSTR_W; i++) rev_instr[i] = v[INSTR_W-1-i];
  endfunction

  function automatic logic [DATA_W-1:0] rev_byte(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i++) rev_byte[i] = v[DATA_W-1-i];
  endfunction

  // low nibble must be the high nibble reversed, long bit must be set
  function automatic logic ctrl_ok(input logic [DATA_W-1:0] v);
    ctrl_ok = v[B_LONG];
    for (int i = 0; i < DATA_W/2; i++) ctrl_ok = ctrl_ok & (v[i] == v[DATA_W-1-i]);
  endfunction
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cs_rise_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              soft_rst_o,
  output logic              lsb_act_o,
  output logic              bidir_act_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic lsb_q, bidir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_DEF;
    end else if (ctrl_q[B_SOFT]) begin
      ctrl_q <= CTRL_DEF;
    end else if (wr_i && ctrl_ok(wdata_i)) begin
      ctrl_q <= wdata_i;
    end
  end

  // active settings follow the register only at frame end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q   <= CTRL_DEF[B_LSB];
      bidir_q <= CTRL_DEF[B_BIDIR];
    end else if (ctrl_q[B_SOFT]) begin
      lsb_q   <= CTRL_DEF[B_LSB];
      bidir_q <= CTRL_DEF[B_BIDIR];
    end else if (cs_rise_i) begin
      lsb_q   <= ctrl_q[B_LSB];
      bidir_q <= ctrl_q[B_BIDIR];
    end
  end

  assign ctrl_o      = ctrl_q;
  assign soft_rst_o  = ctrl_q[B_SOFT];
  assign lsb_act_o   = lsb_q;
  assign bidir_act_o = bidir_q;
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              lsb_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ctrl_wr_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              ext_we_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tx_bit_o,
  output logic              tx_vld_o,
  output logic              cs_rise_o
);
  logic                sclk_q, cs_q, ld_pend;
  logic [CNT_W-1:0]    cnt;
  logic [INSTR_W-2:0]  sh;
  logic [INSTR_W-1:0]  sh_nxt, instr;
  logic [DATA_W-1:0]   tx, ext_wd;
  logic                ext_we, tx_vld, rise, fall, commit, addr_zero;

  assign rise      = sclk_i & ~sclk_q & ~cs_ni;
  assign fall      = ~sclk_i & sclk_q & ~cs_ni;
  assign sh_nxt    = {sh, sdi_i};
  assign addr_zero = (instr[ADDR_W-1:0] == '0);
  assign commit    = rise && (cnt == CNT_W'(FRAME_W-1)) && !instr[INSTR_W-1];
  assign commit_data_o = lsb_i ? rev_byte(sh_nxt[DATA_W-1:0]) : sh_nxt[DATA_W-1:0];
  assign ctrl_wr_o = commit && addr_zero;
  assign cs_rise_o = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      cnt     <= '0;
      sh      <= '0;
      instr   <= '0;
      ld_pend <= 1'b0;
      tx      <= '0;
      tx_vld  <= 1'b0;
      ext_we  <= 1'b0;
      ext_wd  <= '0;
    end else begin
      sclk_q  <= sclk_i;
      cs_q    <= cs_ni;
      ext_we  <= commit && !addr_zero;
      ld_pend <= 1'b0;
      if (commit && !addr_zero) ext_wd <= commit_data_o;
      if (cs_ni) begin
        cnt    <= '0;
        tx_vld <= 1'b0;
      end else begin
        if (rise && cnt != CNT_W'(FRAME_W)) begin
          cnt <= cnt + 1'b1;
          sh  <= sh_nxt[INSTR_W-2:0];
        end
        if (rise && cnt == CNT_W'(INSTR_W-1)) begin
          instr   <= lsb_i ? rev_instr(sh_nxt) : sh_nxt;
          ld_pend <= 1'b1;
        end
        // read data loaded one clock after the address settles
        if (ld_pend && instr[INSTR_W-1]) begin
          tx     <= lsb_i ? rev_byte(rdata_i) : rdata_i;
          tx_vld <= 1'b1;
        end else if (fall && tx_vld && cnt > CNT_W'(INSTR_W)) begin
          tx <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign ext_we_o    = ext_we;
  assign ext_wdata_o = ext_wd;
  assign addr_o      = instr[ADDR_W-1:0];
  assign tx_bit_o    = tx[DATA_W-1];
  assign tx_vld_o    = tx_vld;
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              soft_rst_o
);
  logic [DATA_W-1:0] ctrl_q, commit_data, rdata_mux;
  logic ctrl_wr, cs_rise, lsb_act, bidir_act, tx_bit, tx_vld, out_on;

  spi_serial_engine u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sclk_i        (sclk_i),
    .cs_ni         (cs_ni),
    .sdi_i         (sdio_i),
    .lsb_i         (lsb_act),
    .rdata_i       (rdata_mux),
    .ctrl_wr_o     (ctrl_wr),
    .commit_data_o (commit_data),
    .ext_we_o      (reg_we_o),
    .ext_wdata_o   (reg_wdata_o),
    .addr_o        (reg_addr_o),
    .tx_bit_o      (tx_bit),
    .tx_vld_o      (tx_vld),
    .cs_rise_o     (cs_rise)
  );

  spi_ctrl_reg u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_wr),
    .wdata_i     (commit_data),
    .cs_rise_i   (cs_rise),
    .ctrl_o      (ctrl_q),
    .soft_rst_o  (soft_rst_o),
    .lsb_act_o   (lsb_act),
    .bidir_act_o (bidir_act)
  );

  assign rdata_mux = (reg_addr_o == '0) ? ctrl_q : reg_rdata_i;
  assign out_on    = tx_vld & ~cs_ni;
  assign sdo_o     = out_on & ~bidir_act & tx_bit;
  assign sdio_o    = out_on & bidir_act & tx_bit;
  assign sdio_oe_o = out_on & bidir_act;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       reg_we_o,
  input logic       soft_rst_o,
  input logic       sdo_o,
  input logic       sdio_oe_o,
  input logic [7:0] ctrl_q,
  input logic       lsb_act,
  input logic       bidir_act
);
  assert_we_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  assert_soft_default_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (ctrl_q == 8'h18) && !lsb_act && !bidir_act);

  assert_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[4] && (ctrl_q[3:0] == {ctrl_q[4], ctrl_q[5], ctrl_q[6], ctrl_q[7]}));

  assert_mode_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$past(cs_ni) && !$past(soft_rst_o)) |-> ($stable(lsb_act) && $stable(bidir_act)));

  assert_oe_scope_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> (!sdo_o && !cs_ni));

  assert_four_wire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bidir_act |-> !sdio_oe_o);
endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .reg_we_o   (reg_we_o),
  .soft_rst_o (soft_rst_o),
  .sdo_o      (sdo_o),
  .sdio_oe_o  (sdio_oe_o),
  .ctrl_q     (ctrl_q),
  .lsb_act    (lsb_act),
  .bidir_act  (bidir_act)
);

// File: tb/spi_reg_port_bench.sv
`timescale 1ns/1ps
module spi_reg_port_bench;
  logic clk_i = 0, rst_ni = 0, sclk_i = 0, cs_ni = 1, sdio_i = 0;
  logic sdio_o, sdio_oe_o, sdo_o, reg_we_o, soft_rst_o;
  logic [14:0] reg_addr_o;
  logic [7:0]  reg_wdata_o, reg_rdata_i;

  spi_reg_port u_spi_reg_port (.*);

  always #5 clk_i = ~clk_i;
  assign reg_rdata_i = reg_addr_o[7:0] ^ 8'h5A;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int we_cyc = -10, soft_cyc = -10, oe_from = 1 << 30;
  bit rd_active = 0, cur_bidir = 0, cur_lsb = 0;
  bit m_lsb = 0, m_bidir = 0;
  logic [7:0]  m_ctrl = 8'h18, exp_wd = 0;
  logic [14:0] exp_addr = 0;
  logic [7:0]  rd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc <= cyc + 1;

  // per-clock model comparison
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      chk(reg_we_o == (cyc == we_cyc), "R4 write strobe timing", reg_we_o, cyc == we_cyc);
      if (reg_we_o) begin
        chk(reg_addr_o == exp_addr, "R4 write address", reg_addr_o, exp_addr);
        chk(reg_wdata_o == exp_wd, "R4 write data", reg_wdata_o, exp_wd);
      end
      chk(soft_rst_o == (cyc == soft_cyc), "R10 soft reset pulse", soft_rst_o, cyc == soft_cyc);
      chk(sdio_oe_o == (rd_active && cur_bidir && cyc >= oe_from), "R7 R6 output enable",
          sdio_oe_o, rd_active && cur_bidir && cyc >= oe_from);
      if (cur_bidir) chk(sdo_o == 1'b0, "R7 sdo quiet in 3-wire", sdo_o, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic bit accept(input logic [7:0] w);
    return w[4] && (w[3:0] == {w[4], w[5], w[6], w[7]});
  endfunction

  task automatic xfer(input bit rw, input logic [14:0] addr, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rdo);
    logic [15:0] ins = {rw, addr};
    bit b, pin;
    rdo = 0;
    @(negedge clk_i);
    cur_lsb = m_lsb; cur_bidir = m_bidir; oe_from = 1 << 30;
    cs_ni = 0; rd_active = rw;
    for (int i = 0; i < nbits; i++) begin
      if (i < 16) b = cur_lsb ? ins[i] : ins[15-i];
      else if (i < 24) b = cur_lsb ? wd[i-16] : wd[23-i];
      else b = 1'b1;
      sdio_i = b; sclk_i = 0;
      repeat (3) @(negedge clk_i);
      if (rw && i >= 16 && i < 24) begin
        pin = cur_bidir ? sdio_o : sdo_o;
        if (cur_lsb) rdo[i-16] = pin; else rdo[23-i] = pin;
      end
      sclk_i = 1;
      if (i == 15 && rw) oe_from = cyc + 2;
      if (i == 23 && !rw) begin
        if (addr != 0) begin we_cyc = cyc + 1; exp_addr = addr; exp_wd = wd; end
        else if (accept(wd) && wd[5]) soft_cyc = cyc + 1;
      end
      repeat (4) @(negedge clk_i);
    end
    sclk_i = 0;
    repeat (2) @(negedge clk_i);
    cs_ni = 1; rd_active = 0;
    if (nbits >= 24 && !rw && addr == 0 && accept(wd)) m_ctrl = wd[5] ? 8'h18 : wd;
    m_lsb = m_ctrl[6]; m_bidir = m_ctrl[7];
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(reg_we_o == 0 && soft_rst_o == 0 && sdo_o == 0 && sdio_oe_o == 0,
        "R1 outputs in reset", {reg_we_o, soft_rst_o, sdo_o, sdio_oe_o}, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    xfer(1, 15'h0, 8'h00, 24, rd);
    chk(rd == 8'h18, "R1 R12 reset control value", rd, 8'h18);

    xfer(0, 15'h1234, 8'hA5, 24, rd);                 // R2 R4 MSB write
    xfer(0, 15'h4001, 8'h3C, 24, rd);
    xfer(1, 15'h0155, 8'h00, 24, rd);                 // R5 R6 4-wire read
    chk(rd == (8'h55 ^ 8'h5A), "R5 R6 4-wire read data", rd, 8'h55 ^ 8'h5A);

    xfer(0, 15'h0, 8'h50, 24, rd);                    // bad mirror
    xfer(0, 15'h0, 8'h42, 24, rd);                    // long bit clear
    xfer(1, 15'h0, 8'h00, 24, rd);
    chk(rd == 8'h18, "R8 rejected control writes", rd, 8'h18);

    xfer(0, 15'h0, 8'h5A, 24, rd);                    // LSB-first, still 4-wire
    xfer(1, 15'h0, 8'h00, 24, rd);
    chk(rd == 8'h5A, "R3 R9 R12 LSB readback of control", rd, 8'h5A);
    xfer(0, 15'h2001, 8'h3C, 24, rd);                 // R3 R4 LSB write
    xfer(1, 15'h0007, 8'h00, 24, rd);
    chk(rd == (8'h07 ^ 8'h5A), "R3 LSB read data", rd, 8'h07 ^ 8'h5A);

    xfer(0, 15'h0, 8'hDB, 24, rd);                    // 3-wire, LSB
    xfer(1, 15'h0033, 8'h00, 24, rd);
    chk(rd == (8'h33 ^ 8'h5A), "R7 R9 3-wire read data", rd, 8'h33 ^ 8'h5A);
    xfer(1, 15'h0, 8'h00, 24, rd);
    chk(rd == 8'hDB, "R7 R12 3-wire control readback", rd, 8'hDB);

    xfer(0, 15'h0, 8'h3C, 24, rd);                    // soft reset
    chk(m_lsb == 0 && m_bidir == 0, "R10 model default", m_lsb, 0);
    xfer(1, 15'h0, 8'h00, 24, rd);
    chk(rd == 8'h18, "R10 control after soft reset", rd, 8'h18);
    xfer(1, 15'h0011, 8'h00, 24, rd);
    chk(rd == (8'h11 ^ 8'h5A), "R10 MSB 4-wire after soft reset", rd, 8'h11 ^ 8'h5A);

    xfer(0, 15'h0005, 8'hFF, 20, rd);                 // R11 aborted frame
    xfer(0, 15'h0, 8'h5A, 12, rd);
    xfer(1, 15'h0, 8'h00, 24, rd);
    chk(rd == 8'h18, "R11 aborted control write ignored", rd, 8'h18);
    xfer(0, 15'h0066, 8'h81, 26, rd);                 // R11 extra edges
    xfer(1, 15'h0066, 8'h00, 24, rd);
    chk(rd == (8'h66 ^ 8'h5A), "R11 read after long frame", rd, 8'h66 ^ 8'h5A);

    repeat (10) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule